// File: doc/BRIEF.md
# Page-buffered flash array engine

This block is the back end of a serial flash device. A serial front end that has already decoded a command hands it three things: a start address, a stream of data bytes, and a commit strobe that carries the operation code. The data bytes collect in a page buffer. On commit the block checks the write-protect input, then holds busy for the operation's own parameterised number of cycles. At the end it updates the array in one step and pulses done.

Four operations are carried out. A program clears bits only, so each cell becomes the AND of its old value and the new byte. A write erases the whole page and then stores the supplied bytes. A page erase and a sector erase set every cell in their range to FFh. A read port with one cycle of latency returns any byte at any time. While an operation is in flight, that port still returns the old contents.

The geometry is scaled down and set by parameters. A byte address is `{sector, page-in-sector, column}`, with widths SEC_W, PIS_W and COL_W. The default has 16-byte pages, 4 pages per sector and 4 sectors, 256 bytes in all. The busy lengths T_PROGRAM, T_WRITE, T_PAGE_ERASE and T_SECTOR_ERASE are scaled from millisecond timings, keeping the write longest among the page operations.

Top module: `flash_page_engine`

## Requirements
- R1: After reset, busy_o and done_o are low and every array byte reads FFh.
- R2: Op code 0 (program) changes only the columns of the loaded page that received data since the last load; each such byte becomes old AND new, and every other byte keeps its value.
- R3: Op code 1 (write) sets each loaded column of the page to exactly the supplied byte and every unloaded column of that page to FFh; other pages are untouched.
- R4: A load sets the page from address bits above COL_W and the start column from address bits [COL_W-1:0]; each data byte goes to the current column, which then advances and wraps from the last column to column 0 of the same page. The loaded bytes persist until the next load, so a later commit with no new load reuses them.
- R5: Op code 2 (page erase) sets every byte of the loaded page to FFh and leaves the rest of the array unchanged.
- R6: Op code 3 (sector erase) sets every byte of the sector holding the loaded page (address bits above COL_W+PIS_W) to FFh and leaves other sectors unchanged.
- R7: With wp_i high, a commit is refused when its first affected page index is below PROT_PAGES; for a sector erase this is the sector's first page. A refused commit leaves busy_o and done_o low and the array unchanged. Pages at or above PROT_PAGES are unaffected by wp_i.
- R8: busy_o rises in the cycle after an accepted commit and stays high for exactly T_PROGRAM, T_WRITE, T_PAGE_ERASE or T_SECTOR_ERASE cycles, according to the op code.
- R9: done_o is high for exactly one cycle, the cycle after busy_o falls. Reads issued from that cycle on return the new contents, with rd_data_o valid one cycle after rd_addr_i.
- R10: While busy_o is high, load, data and commit inputs are ignored: the busy period is not extended, and the buffer and target page are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_i | input | 1 | Write protect for the low page region |
| load_i | input | 1 | Start a buffer session at load_addr_i |
| load_addr_i | input | COL_W+PIS_W+SEC_W | Target page and start column |
| data_valid_i | input | 1 | Data byte strobe (lower priority than load_i and cmd_valid_i) |
| data_i | input | 8 | Data byte |
| cmd_valid_i | input | 1 | Commit strobe (highest priority) |
| cmd_op_i | input | 2 | 0 program, 1 write, 2 page erase, 3 sector erase |
| rd_addr_i | input | COL_W+PIS_W+SEC_W | Read byte address |
| rd_data_o | output | 8 | Read data, one cycle after rd_addr_i |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after column wrap-around: a pointer that spilled into the next page, or failed to wrap, would leave the wrong bytes written in two pages. A second program over already programmed bytes must show the AND. A design that overwrote instead of clearing bits would store the new byte. A write that touches only some columns must fill the rest of the page with FFh, where a program-like implementation would keep the old bytes. Sector erase is checked next to an adjacent sector, and under protection on both sides of the protected boundary. The bench also commits, loads and streams data during a busy period, then commits again with no new load. A design that accepted input while busy would lengthen the busy time, erase the wrong page or program the newly loaded page.

// File: rtl/flash_eng_pkg.sv
`timescale 1ns/1ps
package flash_eng_pkg;

  typedef enum logic [1:0] {
    OP_PROGRAM      = 2'd0,
    OP_WRITE        = 2'd1,
    OP_PAGE_ERASE   = 2'd2,
    OP_SECTOR_ERASE = 2'd3
  } flash_op_e;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  // New value of one cell when an operation completes.
  function automatic logic [7:0] next_cell(flash_op_e op, logic in_page, logic in_sector,
                                           logic loaded, logic [7:0] old_b, logic [7:0] new_b);
    logic [7:0] r;
    r = old_b;
    case (op)
      OP_PROGRAM:    if (in_page && loaded) r = old_b & new_b;
      OP_WRITE:      if (in_page) r = loaded ? new_b : ERASED_BYTE;
      OP_PAGE_ERASE: if (in_page) r = ERASED_BYTE;
      default:       if (in_sector) r = ERASED_BYTE;
    endcase
    return r;
  endfunction

  // A page index below the locked count is protected.
  function automatic logic region_locked(logic [31:0] first_page, logic [31:0] locked_pages);
    return first_page < locked_pages;
  endfunction

endpackage

// File: rtl/flash_page_buffer.sv
`timescale 1ns/1ps
module flash_page_buffer #(
  parameter int COL_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [COL_W-1:0]              col_i,
  input  logic                          wr_i,
  input  logic [7:0]                    byte_i,
  output logic [(1<<COL_W)-1:0][7:0]    bytes_o,
  output logic [(1<<COL_W)-1:0]         loaded_o
);
  localparam int NCOL = 1 << COL_W;

  logic [COL_W-1:0] ptr_q;

  // Column pointer wraps naturally inside the page.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (start_i) begin
      ptr_q <= col_i;
    end else if (wr_i) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    localparam logic [COL_W-1:0] MY_COL = COL_W'(c);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bytes_o[c]  <= '0;
        loaded_o[c] <= 1'b0;
      end else if (start_i) begin
        loaded_o[c] <= 1'b0;
      end else if (wr_i && ptr_q == MY_COL) begin
        bytes_o[c]  <= byte_i;
        loaded_o[c] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/flash_busy_timer.sv
`timescale 1ns/1ps
module flash_busy_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cycles_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             finish_o
);
  logic [CNT_W-1:0] cnt_q;

  assign finish_o = busy_o && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= finish_o;
      if (!busy_o && load_i) begin
        cnt_q  <= cycles_i;
        busy_o <= 1'b1;
      end else if (finish_o) begin
        cnt_q  <= '0;
        busy_o <= 1'b0;
      end else if (busy_o) begin
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/flash_cell_array.sv
`timescale 1ns/1ps
module flash_cell_array
  import flash_eng_pkg::*;
#(
  parameter int COL_W = 4,
  parameter int PIS_W = 2,
  parameter int SEC_W = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              apply_i,
  input  flash_op_e                         op_i,
  input  logic [PIS_W+SEC_W-1:0]            page_i,
  input  logic [(1<<COL_W)-1:0][7:0]        bytes_i,
  input  logic [(1<<COL_W)-1:0]             loaded_i,
  input  logic [COL_W+PIS_W+SEC_W-1:0]      rd_addr_i,
  output logic [7:0]                        rd_data_o
);
  localparam int PGI_W  = PIS_W + SEC_W;
  localparam int ADDR_W = COL_W + PGI_W;
  localparam int NBYTES = 1 << ADDR_W;

  logic [7:0] cells [NBYTES];
  logic [SEC_W-1:0] sec_sel;

  assign sec_sel = page_i[PGI_W-1 -: SEC_W];

  for (genvar g = 0; g < NBYTES; g++) begin : g_cell
    localparam logic [PGI_W-1:0] MY_PAGE = PGI_W'(g >> COL_W);
    localparam logic [SEC_W-1:0] MY_SEC  = SEC_W'(g >> (COL_W + PIS_W));
    localparam int               MY_COL  = g % (1 << COL_W);
    logic in_page, in_sector;
    assign in_page   = (page_i == MY_PAGE);
    assign in_sector = (sec_sel == MY_SEC);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cells[g] <= ERASED_BYTE;
      end else if (apply_i) begin
        cells[g] <= next_cell(op_i, in_page, in_sector, loaded_i[MY_COL],
                              cells[g], bytes_i[MY_COL]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data_o <= '0;
    else        rd_data_o <= cells[rd_addr_i];
  end

endmodule

// File: rtl/flash_page_engine.sv
`timescale 1ns/1ps
module flash_page_engine
  import flash_eng_pkg::*;
#(
  parameter int COL_W          = 4,
  parameter int PIS_W          = 2,
  parameter int SEC_W          = 2,
  parameter int PROT_PAGES     = 4,
  parameter int T_PROGRAM      = 8,
  parameter int T_WRITE        = 22,
  parameter int T_PAGE_ERASE   = 20,
  parameter int T_SECTOR_ERASE = 40
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wp_i,
  input  logic                          load_i,
  input  logic [COL_W+PIS_W+SEC_W-1:0]  load_addr_i,
  input  logic                          data_valid_i,
  input  logic [7:0]                    data_i,
  input  logic                          cmd_valid_i,
  input  logic [1:0]                    cmd_op_i,
  input  logic [COL_W+PIS_W+SEC_W-1:0]  rd_addr_i,
  output logic [7:0]                    rd_data_o,
  output logic                          busy_o,
  output logic                          done_o
);
  localparam int PGI_W = PIS_W + SEC_W;
  localparam int T_A   = (T_PROGRAM > T_WRITE) ? T_PROGRAM : T_WRITE;
  localparam int T_B   = (T_PAGE_ERASE > T_SECTOR_ERASE) ? T_PAGE_ERASE : T_SECTOR_ERASE;
  localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
  localparam int CNT_W = $clog2(T_MAX + 1);

  function automatic logic [CNT_W-1:0] cycles_of(flash_op_e op);
    case (op)
      OP_PROGRAM:    return CNT_W'(T_PROGRAM);
      OP_WRITE:      return CNT_W'(T_WRITE);
      OP_PAGE_ERASE: return CNT_W'(T_PAGE_ERASE);
      default:       return CNT_W'(T_SECTOR_ERASE);
    endcase
  endfunction

  // Named internal events
  logic       idle;
  logic       load_fire, data_fire, cmd_seen, lock_hit, commit_fire, finish_fire;
  flash_op_e  cmd_op, op_q;
  logic [PGI_W-1:0] tgt_page, first_page;
  logic [(1<<COL_W)-1:0][7:0] buf_bytes;
  logic [(1<<COL_W)-1:0]      buf_loaded;

  assign cmd_op      = flash_op_e'(cmd_op_i);
  assign idle        = !busy_o;
  assign cmd_seen    = idle && cmd_valid_i;
  assign load_fire   = idle && load_i && !cmd_valid_i;
  assign data_fire   = idle && data_valid_i && !load_i && !cmd_valid_i;
  assign first_page  = (cmd_op == OP_SECTOR_ERASE) ? ((tgt_page >> PIS_W) << PIS_W) : tgt_page;
  assign lock_hit    = wp_i && region_locked(32'(first_page), 32'(PROT_PAGES));
  assign commit_fire = cmd_seen && !lock_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_page <= '0;
      op_q     <= OP_PROGRAM;
    end else begin
      if (load_fire)   tgt_page <= load_addr_i[COL_W +: PGI_W];
      if (commit_fire) op_q     <= cmd_op;
    end
  end

  flash_page_buffer #(.COL_W(COL_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (load_fire),
    .col_i    (load_addr_i[COL_W-1:0]),
    .wr_i     (data_fire),
    .byte_i   (data_i),
    .bytes_o  (buf_bytes),
    .loaded_o (buf_loaded)
  );

  flash_busy_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (commit_fire),
    .cycles_i (cycles_of(cmd_op)),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .finish_o (finish_fire)
  );

  flash_cell_array #(.COL_W(COL_W), .PIS_W(PIS_W), .SEC_W(SEC_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .apply_i   (finish_fire),
    .op_i      (op_q),
    .page_i    (tgt_page),
    .bytes_i   (buf_bytes),
    .loaded_i  (buf_loaded),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

endmodule

// File: rtl/flash_page_engine_chk.sv
`timescale 1ns/1ps
module flash_page_engine_chk #(
  parameter int COL_W          = 4,
  parameter int PIS_W          = 2,
  parameter int SEC_W          = 2,
  parameter int PROT_PAGES     = 4,
  parameter int T_PROGRAM      = 8,
  parameter int T_WRITE        = 22,
  parameter int T_PAGE_ERASE   = 20,
  parameter int T_SECTOR_ERASE = 40
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wp_i,
  input logic                   cmd_valid_i,
  input logic [1:0]             cmd_op_i,
  input logic                   busy_o,
  input logic                   done_o,
  input logic                   commit_fire,
  input logic [PIS_W+SEC_W-1:0] tgt_page
);
  logic [PIS_W+SEC_W-1:0] chk_first;
  logic                   chk_locked;
  logic [15:0]            run_len;
  logic [1:0]             run_op;
  logic [15:0]            want_len;

  assign chk_first  = (cmd_op_i == 2'd3) ? ((tgt_page >> PIS_W) << PIS_W) : tgt_page;
  assign chk_locked = wp_i && ({16'd0, chk_first} < 32'(PROT_PAGES));
  assign want_len   = (run_op == 2'd0) ? 16'(T_PROGRAM) :
                      (run_op == 2'd1) ? 16'(T_WRITE) :
                      (run_op == 2'd2) ? 16'(T_PAGE_ERASE) : 16'(T_SECTOR_ERASE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_len <= '0;
      run_op  <= '0;
    end else if (commit_fire) begin
      run_len <= '0;
      run_op  <= cmd_op_i;
    end else if (busy_o) begin
      run_len <= run_len + 16'd1;
    end
  end

  // R9
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(busy_o && done_o));
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o);
  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy_o) |-> done_o);
  // R8
  commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) commit_fire |=> busy_o);
  // R8
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy_o) |-> run_len == want_len);
  // R7
  locked_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && !busy_o && chk_locked) |=> !busy_o);
  // R10
  busy_source_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_o) |-> $past(commit_fire));

endmodule

bind flash_page_engine flash_page_engine_chk #(
  .COL_W(COL_W), .PIS_W(PIS_W), .SEC_W(SEC_W), .PROT_PAGES(PROT_PAGES),
  .T_PROGRAM(T_PROGRAM), .T_WRITE(T_WRITE), .T_PAGE_ERASE(T_PAGE_ERASE),
  .T_SECTOR_ERASE(T_SECTOR_ERASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
  .busy_o(busy_o), .done_o(done_o), .commit_fire(commit_fire), .tgt_page(tgt_page)
);

// File: tb/flash_page_engine_test.sv
`timescale 1ns/1ps
module flash_page_engine_test;
  localparam int TP = 8, TW = 22, TPE = 20, TSE = 40;

  logic clk = 1'b0, rst_n = 1'b0, wp = 1'b0;
  logic load = 1'b0, dv = 1'b0, cv = 1'b0;
  logic [7:0] laddr = '0, din = '0, raddr = '0, rdata;
  logic [1:0] op = '0;
  logic busy, done;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] ref_mem [256];
  int bm_page, bm_col;
  bit bm_has [16];
  logic [7:0] bm_dat [16];

  always #2 clk = ~clk;

  flash_page_engine #(.COL_W(4), .PIS_W(2), .SEC_W(2), .PROT_PAGES(4),
    .T_PROGRAM(TP), .T_WRITE(TW), .T_PAGE_ERASE(TPE), .T_SECTOR_ERASE(TSE)) uut (
    .clk(clk), .rst_n(rst_n), .wp_i(wp), .load_i(load), .load_addr_i(laddr),
    .data_valid_i(dv), .data_i(din), .cmd_valid_i(cv), .cmd_op_i(op),
    .rd_addr_i(raddr), .rd_data_o(rdata), .busy_o(busy), .done_o(done));

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(logic [7:0] a);
    load = 1'b1; laddr = a;
    @(negedge clk); load = 1'b0;
    bm_page = a >> 4; bm_col = a & 15;
    for (int i = 0; i < 16; i++) bm_has[i] = 0;
  endtask

  task automatic put(logic [7:0] b);
    dv = 1'b1; din = b;
    @(negedge clk); dv = 1'b0;
    bm_has[bm_col] = 1; bm_dat[bm_col] = b; bm_col = (bm_col + 1) % 16;
  endtask

  task automatic model(int code);
    for (int a = 0; a < 256; a++) begin
      int pg, col;
      pg = a / 16; col = a % 16;
      case (code)
        0: if (pg == bm_page && bm_has[col]) ref_mem[a] = ref_mem[a] & bm_dat[col];
        1: if (pg == bm_page) ref_mem[a] = bm_has[col] ? bm_dat[col] : 8'hFF;
        2: if (pg == bm_page) ref_mem[a] = 8'hFF;
        default: if (a / 64 == bm_page / 4) ref_mem[a] = 8'hFF;
      endcase
    end
  endtask

  function automatic int dur(int code);
    return code == 0 ? TP : code == 1 ? TW : code == 2 ? TPE : TSE;
  endfunction

  // Count busy cycles after a commit issued pre_cycles negedges ago.
  task automatic finish_run(int code, int pre_cycles, string req);
    int n;
    n = pre_cycles;
    while (busy) begin n++; @(negedge clk); end
    check(n == dur(code), req, n, dur(code));
    check(done == 1'b1, "R9 done after busy", done, 1);
    @(negedge clk);
    check(done == 1'b0, "R9 done single cycle", done, 0);
    model(code);
  endtask

  task automatic run_op(int code, string req);
    cv = 1'b1; op = 2'(code);
    @(negedge clk); cv = 1'b0;
    finish_run(code, 0, req);
  endtask

  task automatic refused(int code);
    cv = 1'b1; op = 2'(code);
    @(negedge clk); cv = 1'b0;
    check(busy == 1'b0, "R7 refused busy", busy, 0);
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R7 refused no done", {busy, done}, 0);
  endtask

  task automatic sweep(string req);
    for (int a = 0; a < 256; a++) begin
      raddr = 8'(a);
      @(negedge clk);
      check(rdata == ref_mem[a], req, rdata, ref_mem[a]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 256; a++) ref_mem[a] = 8'hFF;
    bm_page = 0; bm_col = 0;
    for (int i = 0; i < 16; i++) begin bm_has[i] = 0; bm_dat[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 reset flags", {busy, done}, 0);
    sweep("R1 erased after reset");

    // R2 program into erased cells, then AND over programmed cells
    do_load(8'h53);
    put(8'hA5); put(8'h3C); put(8'hF0); put(8'h0F); put(8'h77);
    run_op(0, "R8 program length");
    sweep("R2 program first pass");
    do_load(8'h53);
    put(8'h81); put(8'hFF); put(8'h0C);
    run_op(0, "R8 program length");
    sweep("R2 program AND pass");

    // R3 / R4 partial write with column wrap
    do_load(8'h5E);
    put(8'h11); put(8'h22); put(8'h33); put(8'h44);
    run_op(1, "R8 write length");
    sweep("R3 R4 write with wrap");

    // R5 page erase of a fully written page
    do_load(8'h90);
    for (int i = 0; i < 16; i++) put(8'((i * 37 + 5) & 255));
    run_op(1, "R8 write length");
    sweep("R3 full page write");
    do_load(8'h93);
    run_op(2, "R8 page erase length");
    sweep("R5 page erase");

    // R6 sector erase leaves the neighbouring sector
    do_load(8'h40);
    for (int i = 0; i < 16; i++) put(8'(i * 3));
    run_op(1, "R8 write length");
    do_load(8'h80);
    for (int i = 0; i < 16; i++) put(8'(255 - i));
    run_op(1, "R8 write length");
    do_load(8'h47);
    run_op(3, "R8 sector erase length");
    sweep("R6 sector erase");

    // R7 protection
    wp = 1'b1;
    do_load(8'h02); put(8'h00);
    refused(0);
    do_load(8'h37); put(8'h00);
    refused(1);
    do_load(8'h1C);
    refused(3);
    sweep("R7 protected unchanged");
    do_load(8'h4A); put(8'h6B); put(8'h9D);
    run_op(1, "R7 unprotected write under wp");
    do_load(8'h20); put(8'h12);
    refused(2);
    sweep("R7 boundary page");
    wp = 1'b0;
    do_load(8'h02); put(8'h5A);
    run_op(1, "R7 write with wp low");
    sweep("R7 protect released");

    // R10 inputs while busy; R4 buffer reuse without a new load
    do_load(8'hC0);
    put(8'hDE); put(8'hAD); put(8'hBE); put(8'hEF);
    cv = 1'b1; op = 2'd1;
    @(negedge clk); cv = 1'b0;
    load = 1'b1; laddr = 8'hD5;
    @(negedge clk); load = 1'b0;
    dv = 1'b1; din = 8'h00;
    @(negedge clk); dv = 1'b0;
    cv = 1'b1; op = 2'd2;
    @(negedge clk); cv = 1'b0;
    finish_run(1, 3, "R10 busy not extended");
    sweep("R10 ignored while busy");
    run_op(0, "R4 reuse buffer program length");
    sweep("R4 R10 buffer kept");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule